// File: doc/BRIEF.md
# MII Management Serial Target

This block is the target side of a bit-serial management link. A host moves one bit at a time: a write strobe carries one input bit into a frame decoder, and a read strobe pops one bit out of a response shifter. The decoder waits for a start pattern and an opcode. It then gathers a PHY address and a register address. A write frame goes on to collect sixteen data bits and stores them in a small register file. A read frame loads the addressed value into the output shifter.

The register file holds thirty-two 16-bit registers for each of a parameterised number of PHY addresses. Register 1, the basic status register, is not taken from storage: it reports link state from a link-present input. Any bit that does not fit the frame drops the decoder back to idle, and the host can then resend the frame. Pad timing and bus turnaround are handled elsewhere. Here a strobe is a single-cycle pulse on the block clock.

Top module: `mgmt_serial_target`

## Requirements
- R1: While idle, an input bit of 1 leaves the decoder idle and a 0 advances it. The following bit must be 1, or the decoder returns to idle. The address and data accumulators are zero while the decoder is idle.
- R2: After the start pattern 0,1, the opcode bits 1,0 select a read and the opcode bits 0,1 select a write. Opcode 1,1 or 0,0 returns the decoder to idle.
- R3: After the opcode come five PHY address bits and then five register address bits, each sent MSB first.
- R4: On the fifth register address bit of a read frame, the 16-bit value is loaded into a 32-bit shifter at bit offset 15 and the decoder returns to idle. The first read strobe after the load yields a dummy 0. The next 16 strobes yield the value MSB first, and any further strobes yield 0.
- R5: A write frame then expects turnaround bits 1 then 0. Any other bit aborts to idle and nothing is written.
- R6: After the turnaround come sixteen data bits, MSB first. They are written to the addressed register when the last bit arrives, and the decoder returns to idle.
- R7: A read of register address 1 returns 0x0004 when link_present is high and 0x0000 when it is low. This holds for every PHY address, whatever the register holds.
- R8: Each read strobe puts bit 31 of the shifter on bit_out, which is registered and changes one cycle after the strobe, and shifts the shifter left by one. bit_out holds its value between read strobes.
- R9: PHY addresses at or above NUM_PHY are not backed by storage. Writes to them are ignored, and reads of registers other than 1 return 0xFFFF.
- R10: Synchronous reset sets bit_out to 0, clears the shifter and every stored register to 0, and puts the decoder in idle.
- R11: After any abort, a complete frame sent immediately afterwards is decoded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_wr_stb | input | 1 | One-cycle strobe that delivers bit_wr_val to the decoder |
| bit_wr_val | input | 1 | Serial input bit |
| bit_rd_stb | input | 1 | One-cycle strobe that pops one response bit |
| link_present | input | 1 | Link state reported in register 1 |
| bit_out | output | 1 | Serial response bit, registered |

## Verification
The assertions check the following on every cycle:
- an idle decoder stays idle on a 1 and keeps its accumulators cleared;
- a commit happens only in the data phase and only on a strobe;
- a read load and a write commit never occur together;
- a freshly loaded response has its dummy and trailing bits at zero;
- bit_out holds between read strobes;
- a write to a PHY address without storage leaves the register file untouched.

Only the bench scenarios can show the end-to-end results: read-back of written data through the serial path, the link-status override, and the 0xFFFF answer for unbacked PHY addresses. The same applies to malformed openings, opcodes and turnarounds, and to a clean frame right after each of them.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;
    localparam int SHIFT_W    = 32;
    localparam int RESP_OFS   = 15;
    localparam int REGS_PER   = 1 << ADDR_W;
    localparam int CNT_W      = $clog2(DATA_W) + 1;
    localparam logic [ADDR_W-1:0] STATUS_REG  = 5'd1;
    localparam logic [DATA_W-1:0] LINK_UP_VAL = 16'h0004;
    localparam logic [DATA_W-1:0] NO_PHY_VAL  = 16'hFFFF;

    typedef enum logic [3:0] {
        ST_IDLE, ST_GOT0, ST_START, ST_OP_HI, ST_OP_LO,
        ST_PHY, ST_REG, ST_TA1, ST_TA2, ST_DATA
    } dec_state_t;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regno;
        logic [DATA_W-1:0] data;
    } mgmt_cmd_t;

    function automatic logic [SHIFT_W-1:0] resp_word(input logic [DATA_W-1:0] v);
        return SHIFT_W'(v) << RESP_OFS;
    endfunction
endpackage

// File: rtl/mgmt_frame_dec.sv
module mgmt_frame_dec
    import mgmt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_stb,
    input  logic      bit_in,
    output mgmt_cmd_t cmd
);
    dec_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic              is_rd;
    logic [ADDR_W-1:0] phy_acc;
    logic [ADDR_W-1:0] reg_acc;
    logic [DATA_W-1:0] data_acc;

    always_comb begin
        cmd       = '0;
        cmd.phy   = phy_acc;
        cmd.regno = {reg_acc[ADDR_W-2:0], bit_in};
        cmd.data  = {data_acc[DATA_W-2:0], bit_in};
        if (bit_stb && state == ST_REG && cnt == CNT_W'(ADDR_W-1))
            cmd.rd = is_rd;
        if (bit_stb && state == ST_DATA && cnt == CNT_W'(DATA_W-1)) begin
            cmd.wr    = 1'b1;
            cmd.regno = reg_acc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            is_rd    <= 1'b0;
            phy_acc  <= '0;
            reg_acc  <= '0;
            data_acc <= '0;
        end else begin
            if (state == ST_IDLE) begin
                cnt      <= '0;
                phy_acc  <= '0;
                reg_acc  <= '0;
                data_acc <= '0;
            end
            if (bit_stb) begin
                case (state)
                    ST_IDLE:  state <= bit_in ? ST_IDLE : ST_GOT0;
                    ST_GOT0:  state <= bit_in ? ST_START : ST_IDLE;
                    ST_START: state <= bit_in ? ST_OP_HI : ST_OP_LO;
                    ST_OP_HI: begin
                        is_rd <= 1'b1;
                        state <= bit_in ? ST_IDLE : ST_PHY;
                    end
                    ST_OP_LO: begin
                        is_rd <= 1'b0;
                        state <= bit_in ? ST_PHY : ST_IDLE;
                    end
                    ST_PHY: begin
                        phy_acc <= {phy_acc[ADDR_W-2:0], bit_in};
                        if (cnt == CNT_W'(ADDR_W-1)) begin
                            cnt   <= '0;
                            state <= ST_REG;
                        end else cnt <= cnt + 1'b1;
                    end
                    ST_REG: begin
                        reg_acc <= {reg_acc[ADDR_W-2:0], bit_in};
                        if (cnt == CNT_W'(ADDR_W-1)) begin
                            cnt   <= '0;
                            state <= is_rd ? ST_IDLE : ST_TA1;
                        end else cnt <= cnt + 1'b1;
                    end
                    ST_TA1: state <= bit_in ? ST_TA2 : ST_IDLE;
                    ST_TA2: state <= bit_in ? ST_IDLE : ST_DATA;
                    ST_DATA: begin
                        data_acc <= {data_acc[DATA_W-2:0], bit_in};
                        if (cnt == CNT_W'(DATA_W-1)) begin
                            cnt   <= '0;
                            state <= ST_IDLE;
                        end else cnt <= cnt + 1'b1;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R1: a 1 seen while idle keeps the decoder idle
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && bit_stb && bit_in) |=> state == ST_IDLE);
    // R1: accumulators are cleared by a cycle spent idle
    a_r1_idle_clear: assert property (@(posedge clk) disable iff (rst)
        state == ST_IDLE |=> (phy_acc == '0 && reg_acc == '0 && data_acc == '0));
    // R6: a commit leaves the decoder idle
    a_r6_commit_idle: assert property (@(posedge clk) disable iff (rst)
        cmd.wr |=> state == ST_IDLE);
    // R4: a read load leaves the decoder idle
    a_r4_load_idle: assert property (@(posedge clk) disable iff (rst)
        cmd.rd |=> state == ST_IDLE);
endmodule

// File: rtl/mgmt_regfile.sv
module mgmt_regfile
    import mgmt_pkg::*;
#(
    parameter int NUM_PHY = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_phy,
    input  logic [ADDR_W-1:0] wr_reg,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_phy,
    input  logic [ADDR_W-1:0] rd_reg,
    input  logic              link_present,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = NUM_PHY * REGS_PER;
    localparam int IDX_W = $clog2(DEPTH);

    logic [DEPTH-1:0][DATA_W-1:0] mem;
    logic wr_ok, rd_ok;
    logic [IDX_W-1:0] widx, ridx;

    assign wr_ok = int'(wr_phy) < NUM_PHY;
    assign rd_ok = int'(rd_phy) < NUM_PHY;
    assign widx  = IDX_W'({wr_phy, wr_reg});
    assign ridx  = IDX_W'({rd_phy, rd_reg});

    always_ff @(posedge clk) begin
        if (rst) mem <= '0;
        else if (wr_en && wr_ok) mem[widx] <= wr_data;
    end

    always_comb begin
        if (rd_reg == STATUS_REG) rd_data = link_present ? LINK_UP_VAL : '0;
        else if (rd_ok)           rd_data = mem[ridx];
        else                      rd_data = NO_PHY_VAL;
    end

    // R9: writes to unbacked PHY addresses leave storage unchanged
    a_r9_no_store: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_ok) |=> mem == $past(mem));
    // R10: storage is empty right after reset
    a_r10_clear: assert property (@(posedge clk)
        $past(rst) |-> mem == '0);
endmodule

// File: rtl/mgmt_out_shift.sv
module mgmt_out_shift
    import mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              pop,
    output logic              bit_out
);
    logic [SHIFT_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            bit_out <= 1'b0;
        end else begin
            if (pop) begin
                bit_out <= shreg[SHIFT_W-1];
                shreg   <= shreg << 1;
            end
            if (load) shreg <= resp_word(load_val);
        end
    end

    // R8: output holds between read strobes
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !pop |=> $stable(bit_out));
    // R4: dummy position and trailing bits are zero after a load
    a_r4_dummy_zero: assert property (@(posedge clk) disable iff (rst)
        load |=> (shreg[SHIFT_W-1] == 1'b0 && shreg[RESP_OFS-1:0] == '0));
endmodule

// File: rtl/mgmt_serial_target.sv
module mgmt_serial_target
    import mgmt_pkg::*;
#(
    parameter int NUM_PHY = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_wr_stb,
    input  logic bit_wr_val,
    input  logic bit_rd_stb,
    input  logic link_present,
    output logic bit_out
);
    mgmt_cmd_t         cmd;
    logic [DATA_W-1:0] rd_val;

    mgmt_frame_dec u_dec (
        .clk(clk), .rst(rst), .bit_stb(bit_wr_stb), .bit_in(bit_wr_val), .cmd(cmd)
    );

    mgmt_regfile #(.NUM_PHY(NUM_PHY)) u_rf (
        .clk(clk), .rst(rst),
        .wr_en(cmd.wr), .wr_phy(cmd.phy), .wr_reg(cmd.regno), .wr_data(cmd.data),
        .rd_phy(cmd.phy), .rd_reg(cmd.regno), .link_present(link_present),
        .rd_data(rd_val)
    );

    mgmt_out_shift u_shift (
        .clk(clk), .rst(rst), .load(cmd.rd), .load_val(rd_val),
        .pop(bit_rd_stb), .bit_out(bit_out)
    );

    // R2: a frame is either a read or a write, never both
    a_r2_one_op: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd.rd, cmd.wr}));
    // R6: commits and loads only happen on an input strobe
    a_r6_on_strobe: assert property (@(posedge clk) disable iff (rst)
        (cmd.rd || cmd.wr) |-> bit_wr_stb);
    // R10: output is low right after reset
    a_r10_out_low: assert property (@(posedge clk)
        $past(rst) |-> !bit_out);
endmodule

// File: tb/test_mgmt_serial_target.sv
module test_mgmt_serial_target;
    localparam int NPHY = 2;

    logic clk = 1'b0;
    logic rst, wstb, wval, rstb, link;
    logic bout;
    int total = 0;
    int bad = 0;
    logic [15:0] model [0:3][0:31];

    always #4 clk = ~clk;

    mgmt_serial_target #(.NUM_PHY(NPHY)) i_mgmt_serial_target (
        .clk(clk), .rst(rst), .bit_wr_stb(wstb), .bit_wr_val(wval),
        .bit_rd_stb(rstb), .link_present(link), .bit_out(bout)
    );

    function automatic logic [15:0] expect_val(input int phy, input int rg, input logic lk);
        if (rg == 1)     return lk ? 16'h0004 : 16'h0000;
        if (phy >= NPHY) return 16'hFFFF;
        return model[phy][rg];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_bit(input logic b);
        @(negedge clk); wstb = 1'b1; wval = b;
        @(negedge clk); wstb = 1'b0;
    endtask

    task automatic put_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) put_bit(v[i]);
    endtask

    task automatic pop(output logic b);
        @(negedge clk); rstb = 1'b1;
        @(negedge clk); rstb = 1'b0; b = bout;
    endtask

    task automatic do_write(input int phy, input int rg, input logic [15:0] d);
        put_bits(32'b0101, 4);
        put_bits(32'(phy), 5);
        put_bits(32'(rg), 5);
        put_bits(32'b10, 2);
        put_bits(32'(d), 16);
        if (phy < NPHY) model[phy][rg] = d;
    endtask

    task automatic do_read(input int phy, input int rg, output logic dummy, output logic [15:0] v);
        logic b;
        put_bits(32'b0110, 4);
        put_bits(32'(phy), 5);
        put_bits(32'(rg), 5);
        pop(dummy);
        for (int i = 15; i >= 0; i--) begin
            pop(b);
            v[i] = b;
        end
    endtask

    task automatic read_check(input string req, input int phy, input int rg);
        logic dm;
        logic [15:0] v;
        do_read(phy, rg, dm, v);
        check(req, 32'(v), 32'(expect_val(phy, rg, link)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic dm, b;
        logic [15:0] v;
        void'($urandom(32'h1357));
        for (int p = 0; p < 4; p++) for (int r = 0; r < 32; r++) model[p][r] = 16'h0;
        rst = 1'b1; wstb = 1'b0; wval = 1'b0; rstb = 1'b0; link = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 reset output", 32'(bout), 32'd0);
        read_check("R10 reset storage", 1, 7);

        // R6 / R3 basic write then read, MSB first
        do_write(0, 5, 16'hA5C3);
        do_write(1, 5, 16'h3C5A);
        read_check("R3 phy select", 0, 5);
        read_check("R6 write data", 1, 5);

        // R4 dummy bit, payload, trailing zeros; R8 hold
        do_write(1, 30, 16'hFFFF);
        do_read(1, 30, dm, v);
        check("R4 dummy", 32'(dm), 32'd0);
        check("R4 payload", 32'(v), 32'hFFFF);
        pop(b);
        check("R4 trailing zero", 32'(b), 32'd0);
        do_read(0, 5, dm, v);
        repeat (5) @(negedge clk);
        check("R8 hold", 32'(bout), 32'(v[0]));

        // R7 status override
        do_write(0, 1, 16'h1234);
        link = 1'b1; read_check("R7 link up", 0, 1);
        link = 1'b0; read_check("R7 link down", 0, 1);
        link = 1'b1; read_check("R7 unbacked phy", 3, 1);

        // R9 unbacked phy
        do_write(2, 9, 16'hBEEF);
        read_check("R9 read ffff", 2, 9);
        read_check("R9 no alias", 0, 9);

        // R1 idle preamble and bad start bit, R11 recovery
        put_bits(32'hFFFF_FFFF, 32);
        do_write(0, 12, 16'h0F0F);
        read_check("R1 preamble", 0, 12);
        put_bits(32'b00, 2);
        read_check("R1 r11_ bad start", 0, 12);

        // R2 bad opcodes
        put_bits(32'b0111, 4);
        do_write(1, 12, 16'h7777);
        read_check("R2 op11 recover", 1, 12);
        put_bits(32'b0100, 4);
        read_check("R2 op00 recover", 1, 12);

        // R5 bad turnaround: header then TA 0, then TA 1,1
        put_bits(32'b0101, 4); put_bits(32'd0, 5); put_bits(32'd12, 5); put_bit(1'b0);
        read_check("R5 ta first bad", 0, 12);
        put_bits(32'b0101, 4); put_bits(32'd0, 5); put_bits(32'd12, 5); put_bits(32'b11, 2);
        read_check("R5 ta second bad", 0, 12);
        do_write(0, 12, 16'h9009);
        read_check("R11 after abort", 0, 12);

        // random mix
        for (int k = 0; k < 60; k++) begin
            int phy, rg;
            phy = int'($urandom_range(0, 3));
            rg  = int'($urandom_range(0, 31));
            link = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 1) == 1) do_write(phy, rg, 16'($urandom()));
            else read_check("R6 R9 random", phy, rg);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule